// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one channel of a periodic timer. A 32-bit counter counts down by one on each tick of a free-running prescaler that divides a peripheral clock-enable pulse train. The counter only counts while an external run input is high. When the counter steps down from zero, it reloads from a constant register and raises an underflow flag. The flag drives an interrupt output through an enable bit in the control register.

Software reaches the channel through a word-indexed register bus with a single-cycle write strobe and a combinational read port. Software can load the counter directly. Software can change the reload value, and the new value takes effect at the next underflow. Software can acknowledge the underflow by writing zero to the flag bit. Fields for clock-edge selection and capture control are kept in the control register and read back, but they have no effect.

Top module: `rld_timer_chan`

## Requirements
- R1: After reset, the reload register reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, the control register reads 0, and irq_o is low.
- R2: Register index 0 (byte offset 0x0) is the reload value, index 1 (0x4) is the counter, index 2 (0x8) is control, and index 3 (0xC) always reads 0 and ignores writes.
- R3: Control bits 2:0 select the division. Codes 0, 1, 2, 3 and 4 give one decrement per 4, 16, 64, 256 and 1024 pclk_en pulses. Codes 5 to 7 give no decrements.
- R4: The counter changes only while run_i is high, or on a bus write to index 1. With run_i low, it holds its value.
- R5: When a tick arrives with the counter at 0, the counter loads the reload value in that same tick and the underflow flag (control bit 8) becomes 1.
- R6: Writing control with bit 8 = 0 clears the flag. Writing bit 8 = 1 never sets it.
- R7: irq_o is high exactly when the underflow flag and control bit 5 (interrupt enable) are both 1.
- R8: A write to index 1 loads the counter directly. A write to index 0 leaves the counter unchanged and supplies the value for the next underflow.
- R9: Control bits 7:0 are stored and read back. Bits 9 and 15:10, and everything above bit 15, always read 0.
- R10: The prescaler advances only on cycles where pclk_en is high. With pclk_en held low, the counter does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_en | input | 1 | Peripheral clock enable, one pulse per peripheral clock |
| run_i | input | 1 | Counting allowed while high |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Underflow interrupt |

## Verification
The bench builds the channel with its default parameters: a 32-bit counter and five divide codes, so the prescaler reaches 1024. Every divide ratio, up to the widest, can therefore be measured inside a short run. Each ratio is measured over a run window of an exact multiple of its period. Such a window holds a fixed number of ticks whatever the prescaler's phase, so the expected count does not depend on the phase. Small counter loads bring underflow, reload and flag handling into reach within a few ticks.

// File: rtl/rld_tmr_pkg.sv
package rld_tmr_pkg;
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;

  localparam int STORED_W = 8;  // control bits kept in flops
  localparam int IE_BIT   = 5;  // interrupt enable
  localparam int FLAG_BIT = 8;  // underflow flag
  localparam int PSC_W    = 3;  // prescale select width
endpackage

// File: rtl/rld_tmr_prescale.sv
module rld_tmr_prescale #(
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W   = 2 * NUM_DIV;
  localparam int NUM_SEL = 1 << SEL_W;

  logic [DIV_W-1:0]   div_q;
  logic [NUM_SEL-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (pclk_en_i) div_q <= div_q + 1'b1;
  end

  // Code k ends a period of 4^(k+1) pulses when the low 2(k+1) bits are all ones.
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_tap
    if (k < NUM_DIV) begin : g_live
      assign tap[k] = &div_q[2*k+1:0];
    end else begin : g_dead
      assign tap[k] = 1'b0;
    end
  end

  assign tick_o = pclk_en_i & tap[sel_i];

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rld_tmr_counter.sv
module rld_tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = run_i & tick_i & ~ld_i;
  assign uf_o = step & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '1;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (uf_o) cnt_q <= reload_i;
    else if (step) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ld_i) |=> $stable(cnt_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !ld_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/rld_timer_chan.sv
module rld_timer_chan
  import rld_tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_DIV = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_en,
  input  logic             run_i,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o
);
  localparam int HI_W = CNT_W - STORED_W - 1;

  reg_idx_e            idx;
  logic                wr_reload, wr_count, wr_ctrl;
  logic [CNT_W-1:0]    reload_q;
  logic [STORED_W-1:0] ctrl_q;
  logic                uf_flag;
  logic                uf_pulse;
  logic                tick;
  logic [CNT_W-1:0]    cnt;

  assign idx       = reg_idx_e'(bus_addr);
  assign wr_reload = bus_sel & bus_we & (idx == REG_RELOAD);
  assign wr_count  = bus_sel & bus_we & (idx == REG_COUNT);
  assign wr_ctrl   = bus_sel & bus_we & (idx == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_ctrl)   ctrl_q   <= bus_wdata[STORED_W-1:0];
    end
  end

  // Hardware set wins over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             uf_flag <= 1'b0;
    else if (uf_pulse)                      uf_flag <= 1'b1;
    else if (wr_ctrl && !bus_wdata[FLAG_BIT]) uf_flag <= 1'b0;
  end

  rld_tmr_prescale #(
    .SEL_W  (PSC_W),
    .NUM_DIV(NUM_DIV)
  ) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .pclk_en_i(pclk_en),
    .sel_i    (ctrl_q[PSC_W-1:0]),
    .tick_o   (tick)
  );

  rld_tmr_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .tick_i  (tick),
    .ld_i    (wr_count),
    .ld_val_i(bus_wdata),
    .reload_i(reload_q),
    .cnt_o   (cnt),
    .uf_o    (uf_pulse)
  );

  always_comb begin
    case (idx)
      REG_RELOAD: bus_rdata = reload_q;
      REG_COUNT:  bus_rdata = cnt;
      REG_CTRL:   bus_rdata = {{HI_W{1'b0}}, uf_flag, ctrl_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = uf_flag & ctrl_q[IE_BIT];

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_q[IE_BIT]);

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_flag) |-> $past(uf_pulse));
endmodule

// File: tb/rld_timer_chan_tb.sv
module rld_timer_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk_en = 1'b1;
  logic run_i = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic irq_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rld_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .run_i(run_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] ncyc;
    logic [31:0] start;
    logic [31:0] expv;
  } vec_t;

  // Windows are exact multiples of the divide period, so the phase does not matter.
  localparam vec_t VEC [7] = '{
    '{3'd0, 32'd20,   32'd100, 32'd95},
    '{3'd1, 32'd48,   32'd50,  32'd47},
    '{3'd2, 32'd128,  32'd7,   32'd5},
    '{3'd3, 32'd256,  32'd9,   32'd8},
    '{3'd4, 32'd1024, 32'd3,   32'd2},
    '{3'd5, 32'd64,   32'd20,  32'd20},
    '{3'd7, 32'd64,   32'd20,  32'd20}
  };

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run_i = 1'b1;
    repeat (n) @(negedge clk);
    run_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 0);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 32'hFFFF_FFFF, "R1 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); check(v == 32'hFFFF_FFFF, "R1 count", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check(v == 32'h0, "R1 ctrl", v, 32'h0);
    check(irq_o == 1'b0, "R1 irq", {31'b0, irq_o}, 32'h0);

    // R4 hold while run low, even with ticks present
    repeat (40) @(negedge clk);
    rd(2'd1, v); check(v == 32'hFFFF_FFFF, "R4 hold", v, 32'hFFFF_FFFF);

    // R3 divide table
    for (int i = 0; i < 7; i++) begin
      wr(2'd2, {29'b0, VEC[i].code});
      wr(2'd1, VEC[i].start);
      run_for(int'(VEC[i].ncyc));
      rd(2'd1, v);
      check(v == VEC[i].expv, $sformatf("R3 code %0d", VEC[i].code), v, VEC[i].expv);
    end

    // R5 underflow reload and flag; R8 direct load
    wr(2'd2, 32'h0);
    wr(2'd0, 32'd10);
    wr(2'd1, 32'd2);
    rd(2'd1, v); check(v == 32'd2, "R8 load", v, 32'd2);
    run_for(12);
    rd(2'd1, v); check(v == 32'd10, "R5 reload", v, 32'd10);
    rd(2'd2, v); check(v == 32'h100, "R5 flag", v, 32'h100);
    check(irq_o == 1'b0, "R7 irq masked", {31'b0, irq_o}, 32'h0);

    // R7 enable, R6 clear by 0 and no set by 1
    wr(2'd2, 32'h120);
    #1 check(irq_o == 1'b1, "R7 irq on", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h020);
    #1 check(irq_o == 1'b0, "R6 clear irq", {31'b0, irq_o}, 32'h0);
    rd(2'd2, v); check(v == 32'h020, "R6 cleared", v, 32'h020);
    wr(2'd2, 32'h120);
    rd(2'd2, v); check(v == 32'h020, "R6 no sw set", v, 32'h020);
    check(irq_o == 1'b0, "R6 irq stays low", {31'b0, irq_o}, 32'h0);

    // R8 reload write leaves count, takes effect at next underflow
    wr(2'd0, 32'd3);
    rd(2'd1, v); check(v == 32'd10, "R8 count unchanged", v, 32'd10);
    wr(2'd1, 32'd0);
    run_for(4);
    rd(2'd1, v); check(v == 32'd3, "R8 new reload", v, 32'd3);
    check(irq_o == 1'b1, "R7 irq after underflow", {31'b0, irq_o}, 32'h1);
    wr(2'd2, 32'h0);

    // R10 prescaler frozen without pclk_en
    wr(2'd1, 32'd50);
    @(negedge clk); pclk_en = 1'b0;
    run_for(40);
    @(negedge clk); pclk_en = 1'b1;
    rd(2'd1, v); check(v == 32'd50, "R10 no pclk_en", v, 32'd50);

    // R9 stored and zero bits
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check(v == 32'h0000_00FF, "R9 ctrl mask", v, 32'h0000_00FF);
    wr(2'd2, 32'h0);

    // R2 index 3 reads zero and ignores writes; other registers unaffected
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v); check(v == 32'h0, "R2 capture slot", v, 32'h0);
    rd(2'd0, v); check(v == 32'd3, "R2 reload intact", v, 32'd3);
    rd(2'd1, v); check(v == 32'd50, "R2 count intact", v, 32'd50);

    done = 1'b1;
    finish_run();
  end
endmodule